// File: doc/BRIEF.md
# CEC Receive Address Filter

This block sits behind the header receiver of a CEC bus controller. When a header byte has been taken in, the receiver gives a one-cycle strobe with the 4-bit destination field. The filter then decides two things. First, whether this node drives the acknowledge slot that follows the header. Second, whether the frame is passed up to the receive path at all. It also flags frames sent to every node.

Software sets which logical addresses the node answers to with a 15-bit enable mask, one bit per address. A listen flag lets the node watch traffic meant for other nodes without acknowledging it. The mask and the listen flag are taken in only while the block is disabled. Once the block is enabled, that configuration is frozen. The three verdict outputs are registered. They hold their value until the next header strobe, the end of the frame, or the block being disabled.

Top module: `cec_rx_addr_filter`

## Requirements
- R1: After reset, `ack_req`, `accept` and `bcast` are all 0.
- R2: A header strobe whose destination is an enabled address sets `ack_req`=1, `accept`=1 and `bcast`=0 on the clock edge that samples the strobe.
- R3: Bit i of `own_mask` enables logical address i. For example, a mask of 0x0021 enables addresses 0 and 5 and no others.
- R4: A destination that is not enabled, with listen mode on, gives `accept`=1 and `ack_req`=0.
- R5: A destination that is not enabled, with listen mode off, gives `ack_req`=0, `accept`=0 and `bcast`=0.
- R6: Destination 4'hF is broadcast. It gives `accept`=1, `bcast`=1 and `ack_req`=0, whatever the mask and listen settings are.
- R7: The verdict outputs hold while neither `hdr_valid` nor `frame_end` is high. A `frame_end` pulse clears all three on the next edge. A `hdr_valid` in the same cycle as `frame_end` takes priority and loads a new verdict.
- R8: `own_mask` and `listen` are captured on every edge where `enable`=0. Changes made while `enable`=1 have no effect on later verdicts.
- R9: While `enable`=0, all three outputs are 0 from the next edge on, and `hdr_valid` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Block enable. Configuration is captured while this is low |
| own_mask | input | 15 | Per-address enable mask. Bit i enables address i |
| listen | input | 1 | Listen mode: accept non-matching frames without acknowledging them |
| hdr_valid | input | 1 | One-cycle strobe at the end of header reception |
| hdr_dest | input | 4 | Destination field of the received header |
| frame_end | input | 1 | One-cycle pulse at the end of the frame |
| ack_req | output | 1 | Request to drive the header acknowledge slot |
| accept | output | 1 | Frame is passed to the receiver |
| bcast | output | 1 | Frame is a broadcast |

## Verification
The assertions take it for granted that `hdr_valid` and `frame_end` are single-cycle pulses coming from a receiver that only runs while the block is enabled. They also assume the configuration inputs are meant to be changed only while `enable` is low, because the frozen-configuration property compares the captured copy across cycles in which `enable` stays high. The stimulus lowers `enable` for at least one full edge before it loads a new mask and listen value. It raises `enable` before any header strobe, and it drives every input at the falling edge. One directed case deliberately changes the mask while the block is enabled, to show that the change has no effect.

// File: rtl/cec_rxf_pkg.sv
package cec_rxf_pkg;

  typedef enum logic [1:0] {
    VERDICT_DROP   = 2'd0,
    VERDICT_ACK    = 2'd1,
    VERDICT_LISTEN = 2'd2,
    VERDICT_BCAST  = 2'd3
  } verdict_e;

  // Classify a header from the decoded match results and the listen flag.
  // Broadcast wins over everything else; a hit wins over listen.
  function automatic verdict_e classify(input logic hit, input logic is_bc,
                                        input logic lsn);
    if (is_bc)    return VERDICT_BCAST;
    else if (hit) return VERDICT_ACK;
    else if (lsn) return VERDICT_LISTEN;
    else          return VERDICT_DROP;
  endfunction

  function automatic logic verdict_ack(input verdict_e v);
    return v == VERDICT_ACK;
  endfunction

  function automatic logic verdict_accept(input verdict_e v);
    return v != VERDICT_DROP;
  endfunction

  function automatic logic verdict_bcast(input verdict_e v);
    return v == VERDICT_BCAST;
  endfunction

endpackage

// File: rtl/cec_rxf_cfg.sv
module cec_rxf_cfg #(
  parameter int NUM_ADDR = 15
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic [NUM_ADDR-1:0] mask_in,
  input  logic                listen_in,
  output logic [NUM_ADDR-1:0] mask_q,
  output logic                listen_q
);

  // Shadow copy: follows the inputs only while the block is disabled.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q   <= '0;
      listen_q <= 1'b0;
    end else if (!enable) begin
      mask_q   <= mask_in;
      listen_q <= listen_in;
    end
  end

endmodule

// File: rtl/cec_rxf_match.sv
module cec_rxf_match #(
  parameter int NUM_ADDR = 15,
  localparam int DEST_W  = $clog2(NUM_ADDR + 1)
) (
  input  logic [NUM_ADDR-1:0] mask,
  input  logic [DEST_W-1:0]   dest,
  output logic                hit,
  output logic                is_bc
);

  localparam logic [DEST_W-1:0] BCAST_ADDR = DEST_W'(NUM_ADDR);

  logic [NUM_ADDR-1:0] lane_hit;

  // One comparator per logical address, gated by its mask bit.
  for (genvar i = 0; i < NUM_ADDR; i++) begin : g_lane
    assign lane_hit[i] = mask[i] && (dest == DEST_W'(i));
  end

  assign hit   = |lane_hit;
  assign is_bc = (dest == BCAST_ADDR);

endmodule

// File: rtl/cec_rxf_verdict.sv
module cec_rxf_verdict
  import cec_rxf_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic hdr_valid,
  input  logic frame_end,
  input  logic hit,
  input  logic is_bc,
  input  logic listen,
  output logic ack_req,
  output logic accept,
  output logic bcast
);

  verdict_e next_v;
  assign next_v = classify(hit, is_bc, listen);

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      ack_req <= 1'b0;
      accept  <= 1'b0;
      bcast   <= 1'b0;
    end else if (hdr_valid) begin
      ack_req <= verdict_ack(next_v);
      accept  <= verdict_accept(next_v);
      bcast   <= verdict_bcast(next_v);
    end else if (frame_end) begin
      ack_req <= 1'b0;
      accept  <= 1'b0;
      bcast   <= 1'b0;
    end
  end

endmodule

// File: rtl/cec_rx_addr_filter.sv
module cec_rx_addr_filter #(
  parameter int NUM_ADDR = 15,
  localparam int DEST_W  = $clog2(NUM_ADDR + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic [NUM_ADDR-1:0] own_mask,
  input  logic                listen,
  input  logic                hdr_valid,
  input  logic [DEST_W-1:0]   hdr_dest,
  input  logic                frame_end,
  output logic                ack_req,
  output logic                accept,
  output logic                bcast
);

  // Named internal events, visible to the bound checker.
  logic [NUM_ADDR-1:0] cfg_mask;
  logic                cfg_listen;
  logic                dest_hit;
  logic                dest_bc;

  cec_rxf_cfg #(.NUM_ADDR(NUM_ADDR)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .mask_in   (own_mask),
    .listen_in (listen),
    .mask_q    (cfg_mask),
    .listen_q  (cfg_listen)
  );

  cec_rxf_match #(.NUM_ADDR(NUM_ADDR)) u_match (
    .mask  (cfg_mask),
    .dest  (hdr_dest),
    .hit   (dest_hit),
    .is_bc (dest_bc)
  );

  cec_rxf_verdict u_verdict (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .hdr_valid (hdr_valid),
    .frame_end (frame_end),
    .hit       (dest_hit),
    .is_bc     (dest_bc),
    .listen    (cfg_listen),
    .ack_req   (ack_req),
    .accept    (accept),
    .bcast     (bcast)
  );

endmodule

// File: rtl/cec_rx_addr_filter_chk.sv
module cec_rx_addr_filter_chk #(
  parameter int NUM_ADDR = 15,
  localparam int DEST_W  = $clog2(NUM_ADDR + 1)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                enable,
  input logic                hdr_valid,
  input logic [DEST_W-1:0]   hdr_dest,
  input logic                frame_end,
  input logic                ack_req,
  input logic                accept,
  input logic                bcast,
  input logic                dest_hit,
  input logic                cfg_listen,
  input logic [NUM_ADDR-1:0] cfg_mask
);

  assert_ack_needs_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req |-> (accept && !bcast));

  assert_hit_acks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && hdr_valid && dest_hit) |=> (ack_req && accept));

  assert_listen_no_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && hdr_valid && !dest_hit && cfg_listen) |=> (accept && !ack_req));

  assert_miss_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && hdr_valid && !dest_hit && !cfg_listen && hdr_dest != DEST_W'(NUM_ADDR))
      |=> (!accept && !ack_req && !bcast));

  assert_bcast_accepted_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && hdr_valid && hdr_dest == DEST_W'(NUM_ADDR)) |=> (bcast && accept && !ack_req));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !hdr_valid && !frame_end) |=> $stable({ack_req, accept, bcast}));

  assert_frame_end_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !hdr_valid) |=> (!accept && !ack_req && !bcast));

  assert_cfg_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    enable |=> (!enable || ($stable(cfg_mask) && $stable(cfg_listen))));

  assert_disabled_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!accept && !ack_req && !bcast));

endmodule

bind cec_rx_addr_filter cec_rx_addr_filter_chk #(.NUM_ADDR(NUM_ADDR)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .enable     (enable),
  .hdr_valid  (hdr_valid),
  .hdr_dest   (hdr_dest),
  .frame_end  (frame_end),
  .ack_req    (ack_req),
  .accept     (accept),
  .bcast      (bcast),
  .dest_hit   (dest_hit),
  .cfg_listen (cfg_listen),
  .cfg_mask   (cfg_mask)
);

// File: tb/sim_cec_rx_addr_filter.sv
module sim_cec_rx_addr_filter;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        enable;
  logic [14:0] own_mask;
  logic        listen;
  logic        hdr_valid;
  logic [3:0]  hdr_dest;
  logic        frame_end;
  logic        ack_req, accept, bcast;

  int n_run  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  cec_rx_addr_filter u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .own_mask(own_mask),
    .listen(listen), .hdr_valid(hdr_valid), .hdr_dest(hdr_dest),
    .frame_end(frame_end), .ack_req(ack_req), .accept(accept), .bcast(bcast)
  );

  // Vector layout: {mask[14:0], listen, dest[3:0], exp_ack, exp_accept, exp_bcast}
  localparam int NVEC = 12;
  localparam logic [22:0] VEC [NVEC] = '{
    {15'h0021, 1'b0, 4'h0, 3'b110},   // R2 R3
    {15'h0021, 1'b0, 4'h5, 3'b110},   // R2 R3
    {15'h0021, 1'b0, 4'h1, 3'b000},   // R3 R5
    {15'h0021, 1'b1, 4'h1, 3'b010},   // R4
    {15'h0021, 1'b0, 4'hF, 3'b011},   // R6
    {15'h0000, 1'b0, 4'hF, 3'b011},   // R6
    {15'h7FFF, 1'b1, 4'hF, 3'b011},   // R6
    {15'h4000, 1'b0, 4'hE, 3'b110},   // R3 top bit
    {15'h4000, 1'b0, 4'hD, 3'b000},   // R5
    {15'h0000, 1'b1, 4'h7, 3'b010},   // R4
    {15'h7FFF, 1'b0, 4'h9, 3'b110},   // R2
    {15'h0100, 1'b0, 4'h8, 3'b110}    // R3
  };

  task automatic step();
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {ack,accept,bcast} actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic configure(input logic [14:0] m, input logic l);
    enable = 1'b0; own_mask = m; listen = l;
    step();
    enable = 1'b1;
    step();
  endtask

  task automatic header(input logic [3:0] d);
    hdr_valid = 1'b1; hdr_dest = d;
    step();
    hdr_valid = 1'b0;
  endtask

  initial begin
    #1500000;
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; enable = 1'b0; own_mask = '0; listen = 1'b0;
    hdr_valid = 1'b0; hdr_dest = '0; frame_end = 1'b0;
    step(); step();
    check("R1 reset", {ack_req, accept, bcast}, 3'b000);
    rst_n = 1'b1;
    step();
    check("R1 after release", {ack_req, accept, bcast}, 3'b000);

    for (int i = 0; i < NVEC; i++) begin
      configure(VEC[i][22:8], VEC[i][7]);
      header(VEC[i][6:3]);
      check($sformatf("R2-6 vector %0d", i), {ack_req, accept, bcast}, VEC[i][2:0]);
      frame_end = 1'b1;
      step();
      frame_end = 1'b0;
      check($sformatf("R7 clear vector %0d", i), {ack_req, accept, bcast}, 3'b000);
    end

    // R7: the verdict holds across idle cycles
    configure(15'h0021, 1'b0);
    header(4'h5);
    step(); step(); step();
    check("R7 hold", {ack_req, accept, bcast}, 3'b110);
    // R7: hdr_valid in the same cycle as frame_end wins
    frame_end = 1'b1; hdr_valid = 1'b1; hdr_dest = 4'hF;
    step();
    frame_end = 1'b0; hdr_valid = 1'b0;
    check("R7 strobe priority", {ack_req, accept, bcast}, 3'b011);

    // R8: changing config while enabled has no effect
    configure(15'h0021, 1'b0);
    own_mask = 15'h0002; listen = 1'b1;
    step();
    header(4'h1);
    check("R8 frozen mask/listen", {ack_req, accept, bcast}, 3'b000);
    header(4'h0);
    check("R8 old mask used", {ack_req, accept, bcast}, 3'b110);

    // R9: disabling clears outputs, and strobes are ignored while disabled
    enable = 1'b0;
    step();
    check("R9 disable clears", {ack_req, accept, bcast}, 3'b000);
    own_mask = 15'h0021; listen = 1'b0;
    header(4'h0);
    check("R9 strobe ignored", {ack_req, accept, bcast}, 3'b000);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule